// File: doc/BRIEF.md
# Port Boundary Scan Data Register

This block is the boundary scan data register placed between the general-purpose port logic of a core and the device pads. An external test access port controller drives it with capture, shift and update strobes and with a decoded two-bit instruction code. For each pad the register holds two scan cells: one for the output enable and one for the pad data. One further cell controls the weak pull-up enable that is shared by the ports. Every cell has a shift stage in the serial chain and an update latch behind it.

When the external-test instruction is selected, the update latches drive the pad enables, the pad data and the pull-up enable, and every input that goes from a pad to the core is held at logic 1. When the sample instruction is selected, the chain captures the live signals while the core keeps control of the pads. Shifting also presets the update latches, but they do not drive the pads. Any other instruction makes the register transparent.

Top module: `port_bscan_reg`

## Requirements
- R1: An active-low asynchronous reset clears every shift stage and every update latch to 0.
- R2: On a clock edge with `shift_en` high and `capture_en` low, each chain bit takes the value of the bit above it, `tdi` enters the top bit (2*NUM_PINS), and `tdo` always shows chain bit 0. Shifting works under every instruction code.
- R3: Chain bit positions: pad k uses bit 2k for its output enable and bit 2k+1 for its data. The pull-up enable cell is bit 2*NUM_PINS.
- R4: Instruction codes are 2'b10 for external test and 2'b01 for sample; 2'b00 and 2'b11 select neither. With `capture_en` high under either of the two test codes, the enable cells load `core_oe`, the data cells load `pin_in` and the pull-up cell loads `core_pullup_en`. Capture takes priority over shift.
- R5: `capture_en` under any other instruction code leaves the chain unchanged.
- R6: `update_en` under the external-test or sample code copies the chain into the update latches. At all other times the latches hold, including under any other instruction code.
- R7: Under external test, `pin_oe`, `pin_out` and `pin_pullup_en` are driven from the update latches of their cells.
- R8: Under external test, every bit of `core_in` is 1.
- R9: Under sample, and under any other instruction code, `pin_oe`, `pin_out` and `pin_pullup_en` follow `core_oe`, `core_out` and `core_pullup_en`, and `core_in` follows `pin_in`.

Top module parameter: `NUM_PINS` (default 8); the chain is 2*NUM_PINS+1 bits long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr | input | 2 | Decoded instruction: 2'b10 external test, 2'b01 sample, other values neither |
| capture_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| update_en | input | 1 | Update strobe |
| tdi | input | 1 | Serial scan input |
| tdo | output | 1 | Serial scan output (chain bit 0) |
| core_oe | input | NUM_PINS | Output enables from the core |
| core_out | input | NUM_PINS | Output data from the core |
| core_pullup_en | input | 1 | Weak pull-up enable from the core |
| core_in | output | NUM_PINS | Pad input levels delivered to the core |
| pin_in | input | NUM_PINS | Levels sensed at the pads |
| pin_oe | output | NUM_PINS | Output enables to the pad drivers |
| pin_out | output | NUM_PINS | Output data to the pad drivers |
| pin_pullup_en | output | 1 | Weak pull-up enable to the pads |

## Verification
Five behaviours are checked by the assertions on every cycle: the source selection for pads and core inputs under each instruction code, the forcing of core inputs under external test, the one-place move of the chain on a shift, the cell contents after a capture under a test code, and that the chain and the latches hold when a strobe is ignored. The full bit ordering of the chain and the exact pad values after a complete shift-and-update sequence can only be shown by the bench scenarios. These include exhaustive sweeps over the captured patterns and the updated patterns on a four-pad configuration. The bench scenarios also show that a latch preset under sample appears on the pads only after the instruction changes to external test.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic [1:0] {
        INSTR_NONE_LO = 2'b00,
        INSTR_SAMPLE  = 2'b01,
        INSTR_EXTEST  = 2'b10,
        INSTR_NONE_HI = 2'b11
    } bsr_instr_e;

    typedef struct packed {
        logic sh;
        logic up;
    } bsr_cell_t;

endpackage

// File: rtl/bsr_cell.sv
module bsr_cell
    import bsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cap_en,
    input  logic shift_en,
    input  logic upd_en,
    input  logic cap_val,
    input  logic ser_in,
    output logic ser_out,
    output logic upd_val
);

    bsr_cell_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        if (cap_en) begin
            cell_d.sh = cap_val;
        end else if (shift_en) begin
            cell_d.sh = ser_in;
        end
        if (upd_en) begin
            cell_d.up = cell_q.sh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_q <= '0;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign ser_out = cell_q.sh;
    assign upd_val = cell_q.up;

endmodule

// File: rtl/bsr_pin_mux.sv
module bsr_pin_mux (
    input  logic ext_sel,
    input  logic core_oe_i,
    input  logic core_out_i,
    input  logic upd_oe_i,
    input  logic upd_out_i,
    input  logic pad_in_i,
    output logic pad_oe_o,
    output logic pad_out_o,
    output logic core_in_o
);

    always_comb begin
        if (ext_sel) begin
            pad_oe_o  = upd_oe_i;
            pad_out_o = upd_out_i;
            core_in_o = 1'b1;
        end else begin
            pad_oe_o  = core_oe_i;
            pad_out_o = core_out_i;
            core_in_o = pad_in_i;
        end
    end

endmodule

// File: rtl/port_bscan_reg.sv
module port_bscan_reg
    import bsr_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          instr,
    input  logic                capture_en,
    input  logic                shift_en,
    input  logic                update_en,
    input  logic                tdi,
    output logic                tdo,
    input  logic [NUM_PINS-1:0] core_oe,
    input  logic [NUM_PINS-1:0] core_out,
    input  logic                core_pullup_en,
    output logic [NUM_PINS-1:0] core_in,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_out,
    output logic                pin_pullup_en
);

    localparam int CHAIN_LEN = 2 * NUM_PINS + 1;
    localparam int PU_POS    = 2 * NUM_PINS;

    logic                 ext_sel;
    logic                 scan_sel;
    logic                 cap_gated;
    logic                 upd_gated;
    logic [CHAIN_LEN-1:0] chain_q;
    logic [CHAIN_LEN-1:0] upd_q;
    logic [CHAIN_LEN-1:0] cap_vec;
    logic [CHAIN_LEN-1:0] ser_in_vec;

    assign ext_sel   = (instr == INSTR_EXTEST);
    assign scan_sel  = ext_sel || (instr == INSTR_SAMPLE);
    assign cap_gated = capture_en && scan_sel;
    assign upd_gated = update_en && scan_sel;

    assign ser_in_vec = {tdi, chain_q[CHAIN_LEN-1:1]};
    assign tdo        = chain_q[0];

    // capture sources: even = enable from core, odd = level at pad
    generate
        for (genvar k = 0; k < NUM_PINS; k++) begin : g_cap
            assign cap_vec[2*k]   = core_oe[k];
            assign cap_vec[2*k+1] = pin_in[k];
        end
    endgenerate
    assign cap_vec[PU_POS] = core_pullup_en;

    generate
        for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
            bsr_cell u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .cap_en   (cap_gated),
                .shift_en (shift_en),
                .upd_en   (upd_gated),
                .cap_val  (cap_vec[i]),
                .ser_in   (ser_in_vec[i]),
                .ser_out  (chain_q[i]),
                .upd_val  (upd_q[i])
            );
        end
    endgenerate

    generate
        for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
            bsr_pin_mux u_mux (
                .ext_sel    (ext_sel),
                .core_oe_i  (core_oe[k]),
                .core_out_i (core_out[k]),
                .upd_oe_i   (upd_q[2*k]),
                .upd_out_i  (upd_q[2*k+1]),
                .pad_in_i   (pin_in[k]),
                .pad_oe_o   (pin_oe[k]),
                .pad_out_o  (pin_out[k]),
                .core_in_o  (core_in[k])
            );
        end
    endgenerate

    assign pin_pullup_en = ext_sel ? upd_q[PU_POS] : core_pullup_en;

endmodule

// File: rtl/port_bscan_reg_chk.sv
module port_bscan_reg_chk
    import bsr_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [1:0]              instr,
    input logic                    capture_en,
    input logic                    shift_en,
    input logic                    update_en,
    input logic                    tdi,
    input logic [NUM_PINS-1:0]     core_oe,
    input logic [NUM_PINS-1:0]     core_out,
    input logic                    core_pullup_en,
    input logic [NUM_PINS-1:0]     core_in,
    input logic [NUM_PINS-1:0]     pin_in,
    input logic [NUM_PINS-1:0]     pin_oe,
    input logic [NUM_PINS-1:0]     pin_out,
    input logic                    pin_pullup_en,
    input logic [2*NUM_PINS:0]     chain_q,
    input logic [2*NUM_PINS:0]     upd_q
);

    localparam int TOP = 2 * NUM_PINS;

    logic is_ext, is_smp;
    assign is_ext = (instr == INSTR_EXTEST);
    assign is_smp = (instr == INSTR_SAMPLE);

    // R8: core inputs forced high under external test
    a_r8_core_in_forced: assert property (@(posedge clk) disable iff (!rst_n)
        is_ext |-> (core_in == '1));

    // R9: core keeps the pads outside external test
    a_r9_core_owns_pads: assert property (@(posedge clk) disable iff (!rst_n)
        !is_ext |-> (pin_oe == core_oe && pin_out == core_out &&
                     pin_pullup_en == core_pullup_en && core_in == pin_in));

    // R7: pads follow update latches under external test
    a_r7_latch_drives_pads: assert property (@(posedge clk) disable iff (!rst_n)
        is_ext |-> (pin_oe[0] == upd_q[0] && pin_out[0] == upd_q[1] &&
                    pin_pullup_en == upd_q[TOP]));

    // R2: one-place move toward bit 0
    a_r2_shift_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !capture_en) |=>
            (chain_q == {$past(tdi), $past(chain_q[TOP:1])}));

    // R4: capture loads core enable, pad level and pull-up enable
    a_r4_capture_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_en && (is_ext || is_smp)) |=>
            (chain_q[0] == $past(core_oe[0]) && chain_q[1] == $past(pin_in[0]) &&
             chain_q[TOP] == $past(core_pullup_en)));

    // R5: capture ignored under other codes
    a_r5_capture_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_en && !shift_en && !is_ext && !is_smp) |=> $stable(chain_q));

    // R6: latches hold without an accepted update
    a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(update_en && (is_ext || is_smp)) |=> $stable(upd_q));

endmodule

bind port_bscan_reg port_bscan_reg_chk #(.NUM_PINS(NUM_PINS)) u_chk (.*);

// File: tb/port_bscan_reg_test.sv
module port_bscan_reg_test;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 4;
    localparam int LEN        = 2 * NP + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      instr = 2'b00;
    logic            capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0, tdi = 1'b0;
    logic            tdo;
    logic [NP-1:0]   core_oe = '0, core_out = '0, pin_in = '0;
    logic            core_pullup_en = 1'b0;
    logic [NP-1:0]   core_in, pin_oe, pin_out;
    logic            pin_pullup_en;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    port_bscan_reg #(.NUM_PINS(NP)) uut (
        .clk(clk), .rst_n(rst_n), .instr(instr),
        .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
        .tdi(tdi), .tdo(tdo),
        .core_oe(core_oe), .core_out(core_out), .core_pullup_en(core_pullup_en),
        .core_in(core_in), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out), .pin_pullup_en(pin_pullup_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // shifts in vin (bit 0 first), returns the bits seen on tdo
    task automatic shift_vec(input logic [LEN-1:0] vin, output logic [LEN-1:0] vout);
        for (int i = 0; i < LEN; i++) begin
            @(negedge clk);
            vout[i]  = tdo;
            shift_en = 1'b1;
            tdi      = vin[i];
        end
        @(negedge clk);
        shift_en = 1'b0;
        tdi      = 1'b0;
    endtask

    task automatic pulse_capture();
        @(negedge clk); capture_en = 1'b1;
        @(negedge clk); capture_en = 1'b0;
    endtask

    task automatic pulse_update();
        @(negedge clk); update_en = 1'b1;
        @(negedge clk); update_en = 1'b0;
    endtask

    function automatic logic [LEN-1:0] capt_exp(input logic [NP-1:0] oe,
                                                 input logic [NP-1:0] pin,
                                                 input logic pu);
        logic [LEN-1:0] v;
        for (int k = 0; k < NP; k++) begin
            v[2*k]   = oe[k];
            v[2*k+1] = pin[k];
        end
        v[2*NP] = pu;
        return v;
    endfunction

    function automatic logic [NP-1:0] even_bits(input logic [LEN-1:0] v);
        logic [NP-1:0] r;
        for (int k = 0; k < NP; k++) r[k] = v[2*k];
        return r;
    endfunction

    function automatic logic [NP-1:0] odd_bits(input logic [LEN-1:0] v);
        logic [NP-1:0] r;
        for (int k = 0; k < NP; k++) r[k] = v[2*k+1];
        return r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [LEN-1:0] got, prev, held;
        logic [1:0] other_codes [2];
        other_codes[0] = 2'b00;
        other_codes[1] = 2'b11;

        repeat (3) @(negedge clk);
        // R1: reset state, chain reads all zeros
        check("R1 tdo in reset", {31'b0, tdo}, 32'd0);
        rst_n = 1'b1;
        shift_vec('0, got);
        check("R1 chain cleared", got, 32'd0);
        instr = 2'b10;
        @(negedge clk);
        check("R1 latches cleared", {pin_pullup_en, pin_oe, pin_out}, 32'd0);
        instr = 2'b00;

        // R9: transparent under other codes and sample
        for (int c = 0; c < 3; c++) begin
            instr = (c == 0) ? 2'b00 : (c == 1) ? 2'b11 : 2'b01;
            for (int v = 0; v < 512; v++) begin
                @(negedge clk);
                core_oe = v[3:0]; core_out = v[7:4]; pin_in = v[3:0] ^ v[7:4];
                core_pullup_en = v[8];
                #1;
                check("R9 pads follow core", {pin_pullup_en, pin_oe, pin_out},
                      {core_pullup_en, core_oe, core_out});
                check("R9 core_in follows pad", core_in, pin_in);
            end
        end

        // R4/R3: sample capture sweep, R2 shift order
        instr = 2'b01;
        for (int v = 0; v < 512; v++) begin
            @(negedge clk);
            core_oe = v[3:0]; pin_in = v[7:4]; core_pullup_en = v[8];
            core_out = ~v[3:0];
            pulse_capture();
            shift_vec('0, got);
            check("R4 R3 R2 sampled chain", got, capt_exp(v[3:0], v[7:4], v[8]));
        end

        // R4 capture priority over shift
        @(negedge clk);
        core_oe = 4'hA; pin_in = 4'h5; core_pullup_en = 1'b1;
        capture_en = 1'b1; shift_en = 1'b1; tdi = 1'b0;
        @(negedge clk);
        capture_en = 1'b0; shift_en = 1'b0;
        shift_vec('0, got);
        check("R4 capture beats shift", got, capt_exp(4'hA, 4'h5, 1'b1));

        // R6: preset under sample does not reach pads until external test
        shift_vec(9'h15A, got);
        pulse_update();
        core_oe = 4'h0; core_out = 4'h0; core_pullup_en = 1'b0;
        #1;
        check("R9 sample keeps core on pads", {pin_pullup_en, pin_oe, pin_out}, 32'd0);
        instr = 2'b10;
        @(negedge clk);
        check("R6 R7 sample preset visible", {pin_pullup_en, pin_oe, pin_out},
              {1'b1, even_bits(9'h15A), odd_bits(9'h15A)});

        // R7/R8/R2: external test update sweep
        prev = 9'h15A;
        pin_in = 4'h0;
        for (int v = 0; v < 512; v++) begin
            shift_vec(v[8:0], got);
            check("R2 previous pattern out", got, prev);
            pulse_update();
            #1;
            check("R7 pads from latches", {pin_pullup_en, pin_oe, pin_out},
                  {v[8], even_bits(v[8:0]), odd_bits(v[8:0])});
            check("R8 core_in forced", core_in, 4'hF);
            prev = v[8:0];
        end

        // R6: latches hold while shifting without update
        held = prev;
        shift_vec(~held, got);
        check("R6 hold during shift", {pin_pullup_en, pin_oe, pin_out},
              {held[8], even_bits(held), odd_bits(held)});

        // R5/R6: capture and update ignored under other codes
        foreach (other_codes[j]) begin
            shift_vec(9'h0C3, got);
            instr = other_codes[j];
            core_oe = 4'hF; pin_in = 4'hF; core_pullup_en = 1'b1;
            pulse_capture();
            pulse_update();
            instr = 2'b10;
            @(negedge clk);
            check("R6 update ignored", {pin_pullup_en, pin_oe, pin_out},
                  {held[8], even_bits(held), odd_bits(held)});
            shift_vec(9'h0C3, got);
            check("R5 capture ignored", got, 32'h0C3);
        end

        // R2: shifting works under another code
        instr = 2'b00;
        shift_vec(9'h1F0, got);
        shift_vec('0, got);
        check("R2 shift under other code", got, 32'h1F0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule